// File: doc/BRIEF.md
# JTAG Adapter Command Decoder

This block sits behind the control-transfer path of a JTAG adapter and turns each vendor request into action. A request is an 8-bit opcode, a 16-bit index parameter and a direction flag that says whether the host expects data back. The block holds the adapter's control state: an enable flag, a speed class, and an upgrade mode that hands the pins of a secondary TAP straight to the host. Read-type requests are answered with a short reply of one or two bytes. Every request is acknowledged, including ones the block does not know.

In normal mode, a single-pin write request goes to the keyframe sequencer as a one-byte strobe. In upgrade mode, the same request drives TCK, TMS and TDI of the secondary TAP from the index, and a pin-read request returns the synchronised TDO level. A separate opcode range returns the index plus one, saturating at 0xFFFF, and raises an extend pulse.

Top module: `jtag_cmd_decoder`

## Requirements
- R1: After reset the enable flag is 0. Opcode 0x18 (direction out) sets it and opcode 0x10 (direction out) clears it, starting the cycle after the request.
- R2: While the enable flag is 0, opcode 0x30 and opcodes 0x70..0x7F cause no reply, no sequencer strobe, no extend pulse and no TAP pin change. Opcodes 0x20, 0x38 and 0x40 still answer.
- R3: Opcode 0x20 (direction in) replies with a count of 1 and data equal to the index low byte, with the upper data byte at 0.
- R4: Opcode 0x40 (direction in) replies with a count of 2 and data 0xB503.
- R5: The speed class resets to 0x11. Opcode 0x28 (direction out) loads the index low byte with bit 4 forced to 1.
- R6: Upgrade mode is off after reset. Opcode 0x52 (direction out) with index 1 turns it on and with index 0 turns it off. Any other index leaves it unchanged.
- R7: When enabled and in upgrade mode, opcode 0x30 sets TCK from index bit 0, TMS from index bit 1 and TDI from index bit 2 in the cycle after the request. The lines change only on such requests.
- R8: Opcode 0x38 (direction in) replies with a count of 1. In upgrade mode, data bit 0 is the TDO level after a two-stage synchroniser and TCK does not change. Outside upgrade mode, data bit 0 is the enable flag. All other data bits are 0.
- R9: When enabled, opcodes 0x70..0x7F (direction in) reply with a count of 2 and data equal to the index plus 1, saturating at 0xFFFF. They also raise ext_pulse for exactly one cycle.
- R10: When enabled and not in upgrade mode, opcode 0x30 pulses seq_wr_valid for one cycle with seq_wr_data equal to the index low byte, and the TAP lines stay unchanged.
- R11: An unknown opcode, or a known opcode sent with the wrong direction, causes no state change and no reply.
- R12: Each request is acknowledged by cmd_ack, high for one cycle in the cycle after the request. A reply appears in that same cycle as a one-cycle rsp_valid, with rsp_count giving the number of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe, one cycle per request |
| cmd_dir_in | input | 1 | 1 = host expects reply data |
| cmd_opcode | input | 8 | Request opcode |
| cmd_index | input | 16 | Request parameter |
| cmd_ack | output | 1 | Request acknowledged |
| rsp_valid | output | 1 | Reply present |
| rsp_count | output | 2 | Reply byte count |
| rsp_data | output | 16 | Reply data, byte 0 in bits 7:0 |
| ctl_enable | output | 1 | Enable flag |
| ctl_speed | output | 8 | Speed class |
| ctl_upgrade | output | 1 | Upgrade mode flag |
| seq_wr_valid | output | 1 | Single write strobe to sequencer |
| seq_wr_data | output | 8 | Single write byte |
| ext_pulse | output | 1 | Extend pulse for increment requests |
| tap_tck | output | 1 | Secondary TAP clock |
| tap_tms | output | 1 | Secondary TAP mode select |
| tap_tdi | output | 1 | Secondary TAP data in |
| tap_tdo | input | 1 | Secondary TAP data out, asynchronous |

## Verification
The assertions assume that cmd_valid and its fields are stable and meaningful only at the sampled edge. They also assume that tap_tdo can change at any time, which is why it goes through the synchroniser. The pulse and pin-stability checks depend on requests being separated by at least one idle cycle. The bench meets this by driving each request on the falling edge, dropping cmd_valid one cycle later and checking on the following falling edge. The bench holds tap_tdo steady for several cycles before each TDO read, so the synchronised level has settled when it is checked.

// File: rtl/jcd_pkg.sv
package jcd_pkg;
  localparam int OP_W  = 8;
  localparam int IDX_W = 16;

  localparam logic [OP_W-1:0] OP_DISABLE = 8'h10;
  localparam logic [OP_W-1:0] OP_ENABLE  = 8'h18;
  localparam logic [OP_W-1:0] OP_ECHO    = 8'h20;
  localparam logic [OP_W-1:0] OP_SPEED   = 8'h28;
  localparam logic [OP_W-1:0] OP_PINWR   = 8'h30;
  localparam logic [OP_W-1:0] OP_PINRD   = 8'h38;
  localparam logic [OP_W-1:0] OP_CONST   = 8'h40;
  localparam logic [OP_W-1:0] OP_UPGRADE = 8'h52;
  localparam logic [3:0]      OP_INC_HI  = 4'h7;

  localparam logic [IDX_W-1:0] CONST_WORD = 16'hB503;

  localparam int PIN_TCK = 0;
  localparam int PIN_TMS = 1;
  localparam int PIN_TDI = 2;
  localparam int PIN_N   = 3;

  typedef enum logic [3:0] {
    K_NONE, K_DIS, K_EN, K_ECHO, K_SPEED, K_PINWR, K_PINRD, K_CONST, K_UPG, K_INC
  } cmd_kind_e;

  typedef struct packed {
    logic             valid;
    logic [1:0]       count;
    logic [IDX_W-1:0] data;
  } reply_t;

  function automatic cmd_kind_e classify(input logic [OP_W-1:0] op, input logic dir_in);
    cmd_kind_e k;
    k = K_NONE;
    if (dir_in) begin
      if (op == OP_ECHO)                k = K_ECHO;
      else if (op == OP_PINRD)          k = K_PINRD;
      else if (op == OP_CONST)          k = K_CONST;
      else if (op[7:4] == OP_INC_HI)    k = K_INC;
    end else begin
      if (op == OP_DISABLE)             k = K_DIS;
      else if (op == OP_ENABLE)         k = K_EN;
      else if (op == OP_SPEED)          k = K_SPEED;
      else if (op == OP_PINWR)          k = K_PINWR;
      else if (op == OP_UPGRADE)        k = K_UPG;
    end
    return k;
  endfunction
endpackage

// File: rtl/jcd_ctrl_regs.sv
module jcd_ctrl_regs #(
  parameter int          SPEED_W     = 8,
  parameter int          FORCE_BIT   = 4,
  parameter logic [7:0]  SPEED_RESET = 8'h11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_set,
  input  logic               en_clr,
  input  logic               spd_we,
  input  logic [SPEED_W-1:0] spd_in,
  input  logic               upg_we,
  input  logic               upg_in,
  output logic               enable_q,
  output logic [SPEED_W-1:0] speed_q,
  output logic               upgrade_q
);
  localparam logic [SPEED_W-1:0] FORCE_MASK = SPEED_W'(1) << FORCE_BIT;

  logic               enable_d;
  logic [SPEED_W-1:0] speed_d;
  logic               upgrade_d;

  always_comb begin
    enable_d = enable_q;
    if (en_set)      enable_d = 1'b1;
    else if (en_clr) enable_d = 1'b0;
    speed_d   = spd_in | FORCE_MASK;
    upgrade_d = upg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= 1'b0;
      speed_q   <= SPEED_W'(SPEED_RESET);
      upgrade_q <= 1'b0;
    end else begin
      enable_q <= enable_d;
      if (spd_we) speed_q   <= speed_d;
      if (upg_we) upgrade_q <= upgrade_d;
    end
  end

  // R5
  speed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spd_we |=> (speed_q == ($past(spd_in) | FORCE_MASK)));

  // R1
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable_q) |-> $past(en_set));

  // R6
  upgrade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upg_we |=> $stable(upgrade_q));
endmodule

// File: rtl/jcd_bitbang.sv
module jcd_bitbang #(
  parameter int PIN_N       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bb_we,
  input  logic [PIN_N-1:0] bb_pins,
  input  logic             tdo_in,
  output logic [PIN_N-1:0] pins_q,
  output logic             tdo_sync
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else if (bb_we) pins_q <= bb_pins;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= tdo_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign tdo_sync = sync_q[SYNC_STAGES-1];

  // R7
  pins_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bb_we |=> $stable(pins_q));

  // R7
  pins_follow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bb_we |=> (pins_q == $past(bb_pins)));
endmodule

// File: rtl/jcd_reply.sv
module jcd_reply
  import jcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  reply_t           rep_d,
  output logic             rsp_valid,
  output logic [1:0]       rsp_count,
  output logic [IDX_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_count <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rep_d.valid;
      if (rep_d.valid) begin
        rsp_count <= rep_d.count;
        rsp_data  <= rep_d.data;
      end
    end
  end

  // R12
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_count != 2'd0));

  // R12
  one_byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_count == 2'd1) |-> (rsp_data[15:8] == 8'h00));
endmodule

// File: rtl/jtag_cmd_decoder.sv
module jtag_cmd_decoder
  import jcd_pkg::*;
#(
  parameter logic [7:0] SPEED_RESET = 8'h11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_dir_in,
  input  logic [7:0]  cmd_opcode,
  input  logic [15:0] cmd_index,
  output logic        cmd_ack,
  output logic        rsp_valid,
  output logic [1:0]  rsp_count,
  output logic [15:0] rsp_data,
  output logic        ctl_enable,
  output logic [7:0]  ctl_speed,
  output logic        ctl_upgrade,
  output logic        seq_wr_valid,
  output logic [7:0]  seq_wr_data,
  output logic        ext_pulse,
  output logic        tap_tck,
  output logic        tap_tms,
  output logic        tap_tdi,
  input  logic        tap_tdo
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  cmd_kind_e        kind;
  logic             pinwr_go, bb_go, seq_go, inc_go, upg_we;
  logic [IDX_W-1:0] inc_val;
  reply_t           rep_d;
  logic [PIN_N-1:0] pins_q;
  logic             tdo_sync;
  logic             ack_d, seq_v_d, ext_d;
  logic [7:0]       seq_data_d;

  always_comb begin
    kind     = cmd_valid ? classify(cmd_opcode, cmd_dir_in) : K_NONE;
    pinwr_go = (kind == K_PINWR) && ctl_enable;
    bb_go    = pinwr_go && ctl_upgrade;
    seq_go   = pinwr_go && !ctl_upgrade;
    inc_go   = (kind == K_INC) && ctl_enable;
    upg_we   = (kind == K_UPG) && (cmd_index[15:1] == '0);
    inc_val  = (cmd_index == IDX_MAX) ? IDX_MAX : cmd_index + 1'b1;
  end

  always_comb begin
    rep_d = '0;
    case (kind)
      K_ECHO:  begin rep_d.valid = 1'b1; rep_d.count = 2'd1; rep_d.data = {8'h00, cmd_index[7:0]}; end
      K_CONST: begin rep_d.valid = 1'b1; rep_d.count = 2'd2; rep_d.data = CONST_WORD; end
      K_PINRD: begin
        rep_d.valid = 1'b1;
        rep_d.count = 2'd1;
        rep_d.data  = {15'd0, ctl_upgrade ? tdo_sync : ctl_enable};
      end
      K_INC: if (inc_go) begin rep_d.valid = 1'b1; rep_d.count = 2'd2; rep_d.data = inc_val; end
      default: rep_d = '0;
    endcase
  end

  always_comb begin
    ack_d      = cmd_valid;
    seq_v_d    = seq_go;
    seq_data_d = cmd_index[7:0];
    ext_d      = inc_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ack      <= 1'b0;
      seq_wr_valid <= 1'b0;
      seq_wr_data  <= '0;
      ext_pulse    <= 1'b0;
    end else begin
      cmd_ack      <= ack_d;
      seq_wr_valid <= seq_v_d;
      ext_pulse    <= ext_d;
      if (seq_v_d) seq_wr_data <= seq_data_d;
    end
  end

  jcd_ctrl_regs #(.SPEED_W(8), .FORCE_BIT(4), .SPEED_RESET(SPEED_RESET)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .en_set(kind == K_EN), .en_clr(kind == K_DIS),
    .spd_we(kind == K_SPEED), .spd_in(cmd_index[7:0]),
    .upg_we(upg_we), .upg_in(cmd_index[0]),
    .enable_q(ctl_enable), .speed_q(ctl_speed), .upgrade_q(ctl_upgrade)
  );

  jcd_bitbang #(.PIN_N(PIN_N), .SYNC_STAGES(SYNC_STAGES)) bb_i (
    .clk(clk), .rst_n(rst_n),
    .bb_we(bb_go), .bb_pins(cmd_index[PIN_N-1:0]),
    .tdo_in(tap_tdo), .pins_q(pins_q), .tdo_sync(tdo_sync)
  );

  jcd_reply reply_i (
    .clk(clk), .rst_n(rst_n), .rep_d(rep_d),
    .rsp_valid(rsp_valid), .rsp_count(rsp_count), .rsp_data(rsp_data)
  );

  assign tap_tck = pins_q[PIN_TCK];
  assign tap_tms = pins_q[PIN_TMS];
  assign tap_tdi = pins_q[PIN_TDI];

  // R12
  ack_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_ack);

  // R12
  reply_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ack);

  // R9
  ext_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |-> $past(cmd_valid && cmd_dir_in && cmd_opcode[7:4] == OP_INC_HI && ctl_enable));

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ctl_enable) |=> (!seq_wr_valid && !ext_pulse));

  // R10
  seq_not_in_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wr_valid |-> !$past(ctl_upgrade));
endmodule

// File: tb/jtag_cmd_decoder_tb_top.sv
module jtag_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_dir_in;
  logic [7:0]  cmd_opcode;
  logic [15:0] cmd_index;
  logic        cmd_ack, rsp_valid;
  logic [1:0]  rsp_count;
  logic [15:0] rsp_data;
  logic        ctl_enable, ctl_upgrade;
  logic [7:0]  ctl_speed;
  logic        seq_wr_valid;
  logic [7:0]  seq_wr_data;
  logic        ext_pulse, tap_tck, tap_tms, tap_tdi, tap_tdo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir_in(cmd_dir_in),
    .cmd_opcode(cmd_opcode), .cmd_index(cmd_index), .cmd_ack(cmd_ack),
    .rsp_valid(rsp_valid), .rsp_count(rsp_count), .rsp_data(rsp_data),
    .ctl_enable(ctl_enable), .ctl_speed(ctl_speed), .ctl_upgrade(ctl_upgrade),
    .seq_wr_valid(seq_wr_valid), .seq_wr_data(seq_wr_data), .ext_pulse(ext_pulse),
    .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_tdo(tap_tdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one request; on return the registered results are visible.
  task automatic send(input logic dir, input logic [7:0] op, input logic [15:0] idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dir_in = dir; cmd_opcode = op; cmd_index = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset enable", ctl_enable, 0);
    check("R6 reset upgrade", ctl_upgrade, 0);
    check("R5 reset speed", ctl_speed, 8'h11);
    check("R7 reset pins", {tap_tck, tap_tms, tap_tdi}, 0);
    check("R12 reset reply", rsp_valid, 0);
  endtask

  task automatic t_disabled;
    send(1, 8'h75, 16'h0010);
    check("R12 ack", cmd_ack, 1);
    check("R2 no inc reply", rsp_valid, 0);
    check("R2 no ext", ext_pulse, 0);
    send(0, 8'h30, 16'h0055);
    check("R2 no seq", seq_wr_valid, 0);
    send(1, 8'h20, 16'h1234);
    check("R3 echo valid", rsp_valid, 1);
    check("R3 echo count", rsp_count, 1);
    check("R3 echo data", rsp_data, 16'h0034);
    send(1, 8'h38, 16'h0000);
    check("R8 status disabled", {rsp_valid, rsp_data}, {1'b1, 16'h0000});
    idle(1);
    check("R12 valid one cycle", {rsp_valid, cmd_ack}, 0);
  endtask

  task automatic t_enable_const;
    send(0, 8'h18, 16'h0000);
    check("R1 enable set", ctl_enable, 1);
    send(1, 8'h38, 16'h0000);
    check("R8 status enabled", {rsp_count, rsp_data}, {2'd1, 16'h0001});
    send(1, 8'h40, 16'h0000);
    check("R4 const count", rsp_count, 2);
    check("R4 const data", rsp_data, 16'hB503);
  endtask

  task automatic t_speed;
    send(0, 8'h28, 16'h0003);
    check("R5 speed forced bit", ctl_speed, 8'h13);
    send(0, 8'h28, 16'hAAFF);
    check("R5 speed full", ctl_speed, 8'hFF);
    send(0, 8'h28, 16'h0021);
    check("R5 speed reload", ctl_speed, 8'h31);
  endtask

  task automatic t_seq;
    send(0, 8'h30, 16'h0107);
    check("R10 seq strobe", seq_wr_valid, 1);
    check("R10 seq data", seq_wr_data, 8'h07);
    check("R10 pins unchanged", {tap_tck, tap_tms, tap_tdi}, 0);
    idle(1);
    check("R10 seq one cycle", seq_wr_valid, 0);
  endtask

  task automatic t_upgrade;
    send(0, 8'h52, 16'h0002);
    check("R6 other index ignored", ctl_upgrade, 0);
    send(0, 8'h52, 16'h0001);
    check("R6 upgrade on", ctl_upgrade, 1);
    send(0, 8'h30, 16'h0001);
    check("R7 tck high", {tap_tck, tap_tms, tap_tdi}, 3'b100);
    check("R10 no seq in upgrade", seq_wr_valid, 0);
    send(0, 8'h30, 16'h0006);
    check("R7 tms tdi", {tap_tck, tap_tms, tap_tdi}, 3'b011);
    send(0, 8'h30, 16'h0007);
    tap_tdo = 1'b1;
    idle(4);
    send(1, 8'h38, 16'h0000);
    check("R8 tdo high", {rsp_count, rsp_data}, {2'd1, 16'h0001});
    check("R8 tck untouched", tap_tck, 1);
    tap_tdo = 1'b0;
    idle(4);
    send(1, 8'h38, 16'h0000);
    check("R8 tdo low", rsp_data, 16'h0000);
    send(0, 8'h10, 16'h0000);
    check("R1 enable clear", ctl_enable, 0);
    send(0, 8'h30, 16'h0000);
    check("R2 pins held", {tap_tck, tap_tms, tap_tdi}, 3'b111);
    send(0, 8'h18, 16'h0000);
    send(0, 8'h52, 16'h0000);
    check("R6 upgrade off", ctl_upgrade, 0);
  endtask

  task automatic t_inc;
    send(1, 8'h75, 16'h1233);
    check("R9 inc data", {rsp_valid, rsp_count, rsp_data}, {1'b1, 2'd2, 16'h1234});
    check("R9 ext", ext_pulse, 1);
    idle(1);
    check("R9 ext one cycle", ext_pulse, 0);
    send(1, 8'h7F, 16'hFFFF);
    check("R9 saturate", rsp_data, 16'hFFFF);
    send(1, 8'h70, 16'hFFFE);
    check("R9 top", rsp_data, 16'hFFFF);
  endtask

  task automatic t_unknown;
    send(1, 8'h99, 16'h0001);
    check("R11 ack unknown", cmd_ack, 1);
    check("R11 no reply", rsp_valid, 0);
    send(0, 8'h10, 16'h0000);
    send(1, 8'h18, 16'h0000);
    check("R11 wrong dir enable", ctl_enable, 0);
    send(0, 8'h40, 16'h0000);
    check("R11 wrong dir const", rsp_valid, 0);
    send(1, 8'h28, 16'h0000);
    check("R11 wrong dir speed", ctl_speed, 8'h31);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_dir_in = 1'b0;
    cmd_opcode = '0; cmd_index = '0; tap_tdo = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_disabled();
    t_enable_const();
    t_speed();
    t_seq();
    t_upgrade();
    t_inc();
    t_unknown();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule